// File: doc/BRIEF.md
# USB Device Interrupt Router

This block collects the interrupt events of a USB device controller and turns them into one level-sensitive interrupt line for the system interrupt controller. Endpoint event pulses, a start-of-frame event and three kinds of per-endpoint DMA events are latched into sticky status vectors. Software clears them by writing ones over a simple register bus.

Latched endpoint and frame status is sorted into a high-priority request and a low-priority request. A two-bit priority select picks which of them is used. An event on a non-control endpoint whose interrupt enable is clear does not interrupt the CPU. It raises a DMA service flag for that endpoint instead, and the flag reaches the DMA engine only while DMA is enabled for that endpoint. The DMA event vectors are ORed into three summary bits. These are masked and combined into a DMA request. A global enable gates all three requests onto the registered interrupt line.

Top module: `usb_irq_router`

## Requirements
- R1: An event on a control endpoint (endpoints 0 and 1) always sets that endpoint's bit in the endpoint status register (address 0), whatever its interrupt enable (address 1) holds.
- R2: An event on a non-control endpoint sets its endpoint status bit when its enable bit is set. When the enable bit is clear, the event sets the endpoint's bit in the DMA-flag register (address 4) and leaves the endpoint status register unchanged.
- R3: All status bits (addresses 0, 4, 6, 7, 8 and bit 0 of address 11) are sticky. Writing a one clears a bit. If a set and a clear reach the same bit in the same cycle, the set wins.
- R4: Output `dma_svc` equals the DMA-flag register ANDed with the per-endpoint DMA enable register (address 5).
- R5: The priority select is address 3. Bit 0 selects the frame event and bit 1 selects the fast-endpoint group. A source drives `req_hp` only when it is the only one selected. An unselected source drives `req_lp`. When both bits are set, both sources go to `req_lp`.
- R6: A pending endpoint whose class bit (address 2) is 0 is a slow endpoint. It always drives `req_lp` and never drives `req_hp`.
- R7: The per-endpoint end-of-transfer (address 6), new-descriptor (address 7) and error (address 8) vectors are each ORed into a summary bit, shown at bits 3, 4 and 5 of address 12. `req_dma` is the OR of these summary bits after masking with bits 0, 1 and 2 of address 9.
- R8: `irq` is registered. One cycle after the cause, it equals the global enable (address 10, bit 0) ANDed with the OR of `req_hp`, `req_lp` and `req_dma`. Address 12 bits 0, 1 and 2 show `req_lp`, `req_hp` and `req_dma`.
- R9: After reset, every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when set with bus_sel |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ep_evt | input | NUM_EP | Endpoint event pulses |
| frame_evt | input | 1 | Frame event pulse |
| dma_eot_evt | input | NUM_EP | End-of-transfer pulses |
| dma_ndr_evt | input | NUM_EP | New-descriptor request pulses |
| dma_err_evt | input | NUM_EP | DMA error pulses |
| dma_svc | output | NUM_EP | Per-endpoint DMA service requests |
| req_hp | output | 1 | High-priority request |
| req_lp | output | 1 | Low-priority request |
| req_dma | output | 1 | DMA request |
| irq | output | 1 | Registered interrupt line |

## Verification
An event pulse or register write driven during a cycle changes status, `dma_svc`, `req_hp`, `req_lp`, `req_dma` and the read data at the next rising edge. `irq` follows one edge after that. A write to the priority select, the enables or the DMA mask changes the requests at the same edge as the write. Each expectation goes into the scoreboard with the cycle it is due, counted from the stimulus edge. The monitor compares it on the falling edge of that cycle.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_EP_STAT  = 4'd0,
        A_EP_IEN   = 4'd1,
        A_EP_FAST  = 4'd2,
        A_PRIO     = 4'd3,
        A_DFLAG    = 4'd4,
        A_DMA_EN   = 4'd5,
        A_EOT      = 4'd6,
        A_NDR      = 4'd7,
        A_ERR      = 4'd8,
        A_DIEN     = 4'd9,
        A_GCTRL    = 4'd10,
        A_FRAME    = 4'd11,
        A_SUMMARY  = 4'd12
    } reg_addr_e;

    localparam int N_DKIND = 3;
endpackage

// File: rtl/usb_irq_sticky.sv
module usb_irq_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = (bits_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign q_o = bits_q;
endmodule

// File: rtl/usb_irq_route.sv
module usb_irq_route #(
    parameter int NUM_EP = 16
) (
    input  logic [NUM_EP-1:0] ep_pend_i,
    input  logic [NUM_EP-1:0] ep_fast_i,
    input  logic              frame_pend_i,
    input  logic [1:0]        prio_i,
    output logic              hp_o,
    output logic              lp_o
);
    logic fast_any, slow_any, pick_frame, pick_fast;

    always_comb begin
        fast_any   = |(ep_pend_i & ep_fast_i);
        slow_any   = |(ep_pend_i & ~ep_fast_i);
        pick_frame = prio_i[0] & ~prio_i[1];
        pick_fast  = prio_i[1] & ~prio_i[0];
        hp_o = (pick_frame & frame_pend_i) | (pick_fast & fast_any);
        lp_o = slow_any
             | (~pick_frame & frame_pend_i)
             | (~pick_fast & fast_any);
    end
endmodule

// File: rtl/usb_irq_dma_agg.sv
module usb_irq_dma_agg
    import usb_irq_pkg::*;
#(
    parameter int NUM_EP = 16
) (
    input  logic [N_DKIND-1:0][NUM_EP-1:0] kind_i,
    input  logic [N_DKIND-1:0]             kind_en_i,
    output logic [N_DKIND-1:0]             summary_o,
    output logic                           req_o
);
    for (genvar k = 0; k < N_DKIND; k++) begin : g_kind
        assign summary_o[k] = |kind_i[k];
    end

    assign req_o = |(summary_o & kind_en_i);
endmodule

// File: rtl/usb_irq_router.sv
module usb_irq_router
    import usb_irq_pkg::*;
#(
    parameter int NUM_EP   = 16,
    parameter int NUM_CTRL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_EP-1:0] ep_evt,
    input  logic              frame_evt,
    input  logic [NUM_EP-1:0] dma_eot_evt,
    input  logic [NUM_EP-1:0] dma_ndr_evt,
    input  logic [NUM_EP-1:0] dma_err_evt,
    output logic [NUM_EP-1:0] dma_svc,
    output logic              req_hp,
    output logic              req_lp,
    output logic              req_dma,
    output logic              irq
);
    localparam logic [NUM_EP-1:0] CTRL_MASK = NUM_EP'((64'd1 << NUM_CTRL) - 64'd1);

    typedef struct packed {
        logic [NUM_EP-1:0]  ien;
        logic [NUM_EP-1:0]  fast;
        logic [NUM_EP-1:0]  dma_en;
        logic [1:0]         prio;
        logic [N_DKIND-1:0] dien;
        logic               gen;
        logic               irq;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic                           wr;
    logic [NUM_EP-1:0]              wv;
    logic [NUM_EP-1:0]              ep_stat_q, dreq_q, ep_clr, dreq_clr;
    logic [NUM_EP-1:0]              ep_set, dreq_set;
    logic [NUM_EP-1:0]              ien_q, ep_fast_q;
    logic [1:0]                     prio_q;
    logic [N_DKIND-1:0]             dien_q;
    logic                           gen_q;
    logic [N_DKIND-1:0][NUM_EP-1:0] dk_q, dk_set, dk_clr;
    logic [N_DKIND-1:0]             dsum;
    logic                           frame_q, frame_clr;

    assign wr = bus_sel & bus_we;
    assign wv = bus_wdata[NUM_EP-1:0];

    // event steering: control or enabled endpoints interrupt, others flag DMA
    assign ep_set   = ep_evt & (CTRL_MASK | cfg_q.ien);
    assign dreq_set = ep_evt & ~CTRL_MASK & ~cfg_q.ien;
    assign ep_clr   = (wr && bus_addr == A_EP_STAT) ? wv : '0;
    assign dreq_clr = (wr && bus_addr == A_DFLAG)   ? wv : '0;
    assign frame_clr = wr && bus_addr == A_FRAME && bus_wdata[0];

    usb_irq_sticky #(.W(NUM_EP)) u_ep_stat (
        .clk(clk), .rst_n(rst_n), .set_i(ep_set), .clr_i(ep_clr), .q_o(ep_stat_q)
    );
    usb_irq_sticky #(.W(NUM_EP)) u_dflag (
        .clk(clk), .rst_n(rst_n), .set_i(dreq_set), .clr_i(dreq_clr), .q_o(dreq_q)
    );
    usb_irq_sticky #(.W(1)) u_frame (
        .clk(clk), .rst_n(rst_n), .set_i(frame_evt), .clr_i(frame_clr), .q_o(frame_q)
    );

    assign dk_set[0] = dma_eot_evt;
    assign dk_set[1] = dma_ndr_evt;
    assign dk_set[2] = dma_err_evt;

    for (genvar k = 0; k < N_DKIND; k++) begin : g_dk
        assign dk_clr[k] = (wr && bus_addr == 4'(int'(A_EOT) + k)) ? wv : '0;
        usb_irq_sticky #(.W(NUM_EP)) u_dk (
            .clk(clk), .rst_n(rst_n), .set_i(dk_set[k]), .clr_i(dk_clr[k]), .q_o(dk_q[k])
        );
    end

    usb_irq_route #(.NUM_EP(NUM_EP)) u_route (
        .ep_pend_i(ep_stat_q), .ep_fast_i(cfg_q.fast), .frame_pend_i(frame_q),
        .prio_i(cfg_q.prio), .hp_o(req_hp), .lp_o(req_lp)
    );

    usb_irq_dma_agg #(.NUM_EP(NUM_EP)) u_dagg (
        .kind_i(dk_q), .kind_en_i(cfg_q.dien), .summary_o(dsum), .req_o(req_dma)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            unique case (bus_addr)
                A_EP_IEN: cfg_d.ien    = wv;
                A_EP_FAST: cfg_d.fast  = wv;
                A_PRIO:   cfg_d.prio   = bus_wdata[1:0];
                A_DMA_EN: cfg_d.dma_en = wv;
                A_DIEN:   cfg_d.dien   = bus_wdata[N_DKIND-1:0];
                A_GCTRL:  cfg_d.gen    = bus_wdata[0];
                default: ;
            endcase
        end
        cfg_d.irq = cfg_q.gen & (req_hp | req_lp | req_dma);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_EP_STAT: bus_rdata[NUM_EP-1:0]  = ep_stat_q;
            A_EP_IEN:  bus_rdata[NUM_EP-1:0]  = cfg_q.ien;
            A_EP_FAST: bus_rdata[NUM_EP-1:0]  = cfg_q.fast;
            A_PRIO:    bus_rdata[1:0]         = cfg_q.prio;
            A_DFLAG:   bus_rdata[NUM_EP-1:0]  = dreq_q;
            A_DMA_EN:  bus_rdata[NUM_EP-1:0]  = cfg_q.dma_en;
            A_EOT:     bus_rdata[NUM_EP-1:0]  = dk_q[0];
            A_NDR:     bus_rdata[NUM_EP-1:0]  = dk_q[1];
            A_ERR:     bus_rdata[NUM_EP-1:0]  = dk_q[2];
            A_DIEN:    bus_rdata[N_DKIND-1:0] = cfg_q.dien;
            A_GCTRL:   bus_rdata[0]           = cfg_q.gen;
            A_FRAME:   bus_rdata[0]           = frame_q;
            A_SUMMARY: bus_rdata[5:0]         = {dsum, req_dma, req_hp, req_lp};
            default: ;
        endcase
    end

    assign ien_q     = cfg_q.ien;
    assign ep_fast_q = cfg_q.fast;
    assign prio_q    = cfg_q.prio;
    assign dien_q    = cfg_q.dien;
    assign gen_q     = cfg_q.gen;
    assign dma_svc   = dreq_q & cfg_q.dma_en;
    assign irq       = cfg_q.irq;
endmodule

// File: rtl/usb_irq_router_chk.sv
module usb_irq_router_chk #(
    parameter int NUM_EP   = 16,
    parameter int NUM_CTRL = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EP-1:0] ep_evt,
    input logic [NUM_EP-1:0] ep_stat_q,
    input logic [NUM_EP-1:0] dreq_q,
    input logic [NUM_EP-1:0] ep_fast_q,
    input logic [1:0]        prio_q,
    input logic [2:0]        dien_q,
    input logic              gen_q,
    input logic              req_hp,
    input logic              req_lp,
    input logic              req_dma,
    input logic              irq
);
    a_r1_ctrl_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ep_evt[0] |=> ep_stat_q[0]);

    a_r2_ctrl_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_q[NUM_CTRL-1:0] == '0);

    a_r5_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_q == 2'b11) |-> !req_hp);

    a_r6_slow_lp: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ep_stat_q & ~ep_fast_q)) |-> req_lp);

    a_r7_dma_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (dien_q == 3'b000) |-> !req_dma);

    a_r8_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(gen_q && (req_hp || req_lp || req_dma)));
endmodule

bind usb_irq_router usb_irq_router_chk #(.NUM_EP(NUM_EP), .NUM_CTRL(NUM_CTRL)) u_chk (
    .clk(clk), .rst_n(rst_n), .ep_evt(ep_evt), .ep_stat_q(ep_stat_q),
    .dreq_q(dreq_q), .ep_fast_q(ep_fast_q), .prio_q(prio_q), .dien_q(dien_q),
    .gen_q(gen_q), .req_hp(req_hp), .req_lp(req_lp), .req_dma(req_dma), .irq(irq)
);

// File: tb/usb_irq_router_bench.sv
module usb_irq_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NEP = 16;

    localparam int K_RD = 0, K_IRQ = 1, K_HP = 2, K_LP = 3, K_DMA = 4, K_SVC = 5;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_we = 0;
    logic [3:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [NEP-1:0] ep_evt = 0, dma_eot_evt = 0, dma_ndr_evt = 0, dma_err_evt = 0;
    logic frame_evt = 0;
    logic [NEP-1:0] dma_svc;
    logic req_hp, req_lp, req_dma, irq;

    int cyc = 0, checks = 0, errors = 0;
    bit done = 0;
    item_t sb[$];

    usb_irq_router u_usb_irq_router (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ep_evt(ep_evt), .frame_evt(frame_evt), .dma_eot_evt(dma_eot_evt),
        .dma_ndr_evt(dma_ndr_evt), .dma_err_evt(dma_err_evt), .dma_svc(dma_svc),
        .req_hp(req_hp), .req_lp(req_lp), .req_dma(req_dma), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every item that is due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [31:0] act;
                case (sb[i].kind)
                    K_RD:  act = bus_rdata;
                    K_IRQ: act = {31'd0, irq};
                    K_HP:  act = {31'd0, req_hp};
                    K_LP:  act = {31'd0, req_lp};
                    K_DMA: act = {31'd0, req_dma};
                    default: act = {16'd0, dma_svc};
                endcase
                checks++;
                if (act !== sb[i].exp) begin
                    errors++;
                    $display("FAIL %s kind %0d actual %h expected %h", sb[i].tag, sb[i].kind, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_at(int kind, logic [31:0] exp, string tag, int delay);
        item_t it;
        it.due = cyc + delay; it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        expect_at(K_RD, exp, tag, 0);
        tick();
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic pulse_ep(logic [NEP-1:0] m);
        ep_evt = m;
        tick();
        ep_evt = 0;
    endtask

    task automatic pulse_frame();
        frame_evt = 1;
        tick();
        frame_evt = 0;
    endtask

    task automatic req_chk(logic hp, logic lp, string tag);
        expect_at(K_HP, {31'd0, hp}, tag, 0);
        expect_at(K_LP, {31'd0, lp}, tag, 0);
    endtask

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R9 reset state
        expect_at(K_IRQ, 0, "R9", 0);
        expect_at(K_DMA, 0, "R9", 0);
        req_chk(0, 0, "R9");
        rd(4'd0, 0, "R9");
        rd(4'd1, 0, "R9");
        rd(4'd10, 0, "R9");
        rd(4'd12, 0, "R9");

        wr(4'd1, 32'h000C);   // ep2, ep3 enabled
        wr(4'd2, 32'h0004);   // ep2 fast
        wr(4'd10, 32'h1);     // global enable

        // R1 control endpoint with enable clear
        pulse_ep(16'h0001);
        rd(4'd0, 32'h1, "R1");
        req_chk(0, 1, "R6");
        expect_at(K_IRQ, 1, "R8", 0);
        wr(4'd0, 32'h1);      // R3 write-one clear
        rd(4'd0, 32'h0, "R3");
        expect_at(K_IRQ, 0, "R8", 1);
        tick();

        // R2 disabled non-control endpoints become DMA flags
        pulse_ep(16'h0030);
        rd(4'd0, 32'h0, "R2");
        rd(4'd4, 32'h30, "R2");
        expect_at(K_SVC, 0, "R4", 0);
        wr(4'd5, 32'h10);
        expect_at(K_SVC, 32'h10, "R4", 0);
        wr(4'd4, 32'h30);
        expect_at(K_SVC, 0, "R4", 0);
        rd(4'd4, 32'h0, "R3");

        // R5 priority routing
        wr(4'd3, 32'h1);
        pulse_frame();
        req_chk(1, 0, "R5");
        rd(4'd11, 32'h1, "R5");
        wr(4'd3, 32'h3);
        req_chk(0, 1, "R5");
        wr(4'd3, 32'h2);
        req_chk(0, 1, "R5");
        pulse_ep(16'h0004);   // fast enabled endpoint
        req_chk(1, 1, "R5");
        wr(4'd11, 32'h1);
        req_chk(1, 0, "R5");
        rd(4'd12, 32'h2, "R8");
        wr(4'd3, 32'h3);
        req_chk(0, 1, "R5");
        wr(4'd0, 32'h4);
        req_chk(0, 0, "R5");

        // R6 slow endpoint under fast selection
        wr(4'd3, 32'h2);
        pulse_ep(16'h0008);
        req_chk(0, 1, "R6");

        // R3 set wins over a same-cycle clear
        ep_evt = 16'h0008;
        wr(4'd0, 32'h8);
        ep_evt = 0;
        rd(4'd0, 32'h8, "R3");
        wr(4'd0, 32'h8);
        rd(4'd0, 32'h0, "R3");
        expect_at(K_IRQ, 0, "R8", 1);
        tick();

        // R7 DMA aggregation and masking
        dma_eot_evt = 16'h0020; dma_err_evt = 16'h0002;
        tick();
        dma_eot_evt = 0; dma_err_evt = 0;
        rd(4'd12, 32'h28, "R7");
        expect_at(K_DMA, 0, "R7", 0);
        wr(4'd9, 32'h4);
        expect_at(K_DMA, 1, "R7", 0);
        expect_at(K_IRQ, 1, "R8", 1);
        tick();
        wr(4'd9, 32'h2);
        expect_at(K_DMA, 0, "R7", 0);
        wr(4'd9, 32'h3);
        expect_at(K_DMA, 1, "R7", 0);
        wr(4'd6, 32'h20);
        expect_at(K_DMA, 0, "R7", 0);
        rd(4'd6, 32'h0, "R3");

        // R8 global gating
        wr(4'd10, 32'h0);
        pulse_ep(16'h0001);
        req_chk(0, 1, "R8");
        tick();
        expect_at(K_IRQ, 0, "R8", 0);
        wr(4'd10, 32'h1);
        expect_at(K_IRQ, 1, "R8", 1);
        tick(); tick();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule